// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Block

This block keeps calendar time for a host that reaches it through two byte-wide ports. The host first writes a register index to the index port and then reads the chosen register through the data port. Seconds, minutes, hours, day of week, day of month, month and year are held as plain binary counters. They advance once for every cycle in which the one-second enable `sec_tick` is high, with full calendar carry, including month lengths and leap years.

Three control registers return fixed or self-toggling status values. The update-in-progress bit flips on every read of its register, so a host that polls it always sees it change. A free-running divider produces a one-cycle periodic interrupt pulse at 1024 Hz, derived from the clock frequency. The data port accepts no writes: such a write, a read of an unknown index and a read of the fourth control register each raise a one-cycle error flag. The initial time is loaded from parameters at reset.

Top module: `rtc_idx_regs`

## Requirements
- R1: A cycle with `idx_wr` high latches `wdata` as the index for later data-port reads. The index map is 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week, 0x07 day of month, 0x08 month, 0x09 year, 0x0A control A, 0x0B control B, 0x0C control C and 0x0D control D.
- R2: A read of control A returns 0x26 in bits 6:0 and the update-in-progress bit in bit 7. That bit is 1 after reset and inverts after each read of control A, so the reads return 0xA6, 0x26, 0xA6 and so on.
- R3: A read of control B returns 0x46 and a read of control C returns 0x00.
- R4: The data selected by a cycle with `data_rd` high appears on `rdata` after the next clock edge. `rdata` holds its value until the next read.
- R5: On each `sec_tick`, seconds count 0..59 and carry into minutes. Minutes count 0..59 and carry into hours, and hours count 0..23 and carry into the day. Without `sec_tick` the time does not change.
- R6: Day of week counts 0..6 and wraps from 6 to 0 at each midnight.
- R7: Day of month runs from 1 to the length of the month, which is 30 for months 4, 6, 9 and 11 and 31 for months 1, 3, 5, 7, 8, 10 and 12. The day then returns to 1 and the month, stored 1..12, advances.
- R8: February has 29 days when the year field y (years since 1952) satisfies y mod 4 = 0 and y is neither 148 nor 248, and 28 days otherwise.
- R9: After December 31 23:59:59 the next tick gives January 1 00:00:00 and increments the year. Year 255 wraps to 0.
- R10: `per_irq` is a one-cycle pulse that repeats every CLK_HZ/1024 clock cycles.
- R11: `err` pulses for one cycle after a data-port write, after a read of control D or after a read of any unmapped index. Such a read returns 0x00, and a data-port write changes no time value.
- R12: Reset loads the seven time fields from the INIT_* parameters, and `per_irq` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Write `wdata` to the index port |
| data_wr | input | 1 | Write to the data port (unsupported, flags an error) |
| data_rd | input | 1 | Read the indexed register |
| wdata | input | 8 | Write data for either port |
| sec_tick | input | 1 | One-second advance enable |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle error pulse |
| per_irq | output | 1 | 1024 Hz periodic interrupt pulse |

## Verification
Read data and the error flag are due one clock edge after the cycle that carries `data_rd` or `data_wr`. The bench drives inputs at a falling edge and samples at the following falling edge, so exactly one rising edge lies between stimulus and check. Time fields change on the edge that sees `sec_tick`, and the bench reads them back only after the tick pulse has ended. The interrupt period is measured by counting falling edges between two observed pulses, and the result is compared with CLK_HZ/1024.

// File: rtl/rtc_idx_regs.sv
module rtc_idx_regs #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PI_HZ     = 1024,
  parameter int INIT_SEC  = 0,
  parameter int INIT_MIN  = 0,
  parameter int INIT_HOUR = 0,
  parameter int INIT_DOW  = 0,
  parameter int INIT_DOM  = 1,
  parameter int INIT_MON  = 1,
  parameter int INIT_YEAR = 54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  input  logic       sec_tick,
  output logic [7:0] rdata,
  output logic       err,
  output logic       per_irq
);
  localparam int DIV = CLK_HZ / PI_HZ;
  localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  localparam logic [7:0] IX_SEC = 8'h00, IX_MIN = 8'h02, IX_HR  = 8'h04,
                         IX_DOW = 8'h06, IX_DOM = 8'h07, IX_MON = 8'h08,
                         IX_YR  = 8'h09, IX_A   = 8'h0A, IX_B   = 8'h0B,
                         IX_C   = 8'h0C;

  logic [7:0] idx_q, sec_q, min_q, hr_q, dow_q, dom_q, mon_q, yr_q;
  logic       uip_q;
  logic [CW-1:0] div_q;
  logic [7:0] mdays, rd_val;
  logic       rd_bad;

  wire leap    = (yr_q[1:0] == 2'd0) && (yr_q != 8'd148) && (yr_q != 8'd248);
  wire end_min = (sec_q == 8'd59);
  wire end_hr  = end_min && (min_q == 8'd59);
  wire end_day = end_hr && (hr_q == 8'd23);
  wire end_mon = end_day && (dom_q == mdays);
  wire end_yr  = end_mon && (mon_q == 8'd12);

  always_comb begin
    case (mon_q)
      8'd2:                      mdays = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   mdays = 8'd30;
      default:                   mdays = 8'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'(INIT_SEC);
      min_q <= 8'(INIT_MIN);
      hr_q  <= 8'(INIT_HOUR);
      dow_q <= 8'(INIT_DOW);
      dom_q <= 8'(INIT_DOM);
      mon_q <= 8'(INIT_MON);
      yr_q  <= 8'(INIT_YEAR);
    end else if (sec_tick) begin
      sec_q <= end_min ? 8'd0 : sec_q + 8'd1;
      if (end_min) min_q <= end_hr ? 8'd0 : min_q + 8'd1;
      if (end_hr)  hr_q  <= end_day ? 8'd0 : hr_q + 8'd1;
      if (end_day) begin
        dow_q <= (dow_q == 8'd6) ? 8'd0 : dow_q + 8'd1;
        dom_q <= end_mon ? 8'd1 : dom_q + 8'd1;
      end
      if (end_mon) mon_q <= end_yr ? 8'd1 : mon_q + 8'd1;
      if (end_yr)  yr_q  <= yr_q + 8'd1;
    end
  end

  always_comb begin
    rd_bad = 1'b0;
    case (idx_q)
      IX_SEC:  rd_val = sec_q;
      IX_MIN:  rd_val = min_q;
      IX_HR:   rd_val = hr_q;
      IX_DOW:  rd_val = dow_q;
      IX_DOM:  rd_val = dom_q;
      IX_MON:  rd_val = mon_q;
      IX_YR:   rd_val = yr_q;
      IX_A:    rd_val = {uip_q, 7'h26};
      IX_B:    rd_val = 8'h46;
      IX_C:    rd_val = 8'h00;
      default: begin rd_val = 8'h00; rd_bad = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      uip_q <= 1'b1;
      rdata <= 8'h00;
      err   <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (data_rd) rdata <= rd_val;
      if (data_rd && idx_q == IX_A) uip_q <= ~uip_q;
      err <= data_wr || (data_rd && rd_bad);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      per_irq <= 1'b0;
    end else begin
      per_irq <= (div_q == DIV_LAST);
      div_q   <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_idx_chk.sv
module rtc_idx_chk #(
  parameter int DIV = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       data_rd,
  input logic       data_wr,
  input logic       sec_tick,
  input logic [7:0] idx_q,
  input logic [7:0] rdata,
  input logic       err,
  input logic       per_irq,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hr_q,
  input logic [7:0] dow_q,
  input logic [7:0] dom_q,
  input logic [7:0] mon_q
);
  logic exp_uip;
  int   gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_uip <= 1'b1;
      gap     <= 0;
    end else begin
      if (data_rd && idx_q == 8'h0A) exp_uip <= ~exp_uip;
      gap <= per_irq ? 1 : gap + 1;
    end
  end

  a_r2_ctrl_a: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx_q == 8'h0A) |=> (rdata[6:0] == 7'h26 && rdata[7] == $past(exp_uip)));
  a_r3_ctrl_b: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx_q == 8'h0B) |=> rdata == 8'h46);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(rdata));
  a_r5_ranges: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q < 8'd60 && min_q < 8'd60 && hr_q < 8'd24);
  a_r5_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_q) && $stable(dom_q));
  a_r6_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    dow_q < 8'd7);
  a_r7_date_range: assert property (@(posedge clk) disable iff (!rst_n)
    dom_q >= 8'd1 && dom_q <= 8'd31 && mon_q >= 8'd1 && mon_q <= 8'd12);
  a_r10_period: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> gap == DIV);
  a_r10_width: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |=> !per_irq);
  a_r11_wr_err: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> err);
endmodule

bind rtc_idx_regs rtc_idx_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .data_wr(data_wr),
  .sec_tick(sec_tick), .idx_q(idx_q), .rdata(rdata), .err(err),
  .per_irq(per_irq), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
  .dow_q(dow_q), .dom_q(dom_q), .mon_q(mon_q)
);

// File: tb/rtc_idx_regs_tb.sv
`timescale 1ns/1ps
module rtc_idx_regs_tb;
  localparam int CLK_HZ = 8192;
  localparam int DIV    = CLK_HZ / 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [3:0] tk = 4'b0;
  logic [7:0] rd [4];
  logic       er [4];
  logic       pi [4];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rtc_idx_regs #(.CLK_HZ(CLK_HZ), .INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23),
    .INIT_DOW(6), .INIT_DOM(31), .INIT_MON(12), .INIT_YEAR(255)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .sec_tick(tk[0]), .rdata(rd[0]), .err(er[0]), .per_irq(pi[0]));
  rtc_idx_regs #(.CLK_HZ(CLK_HZ), .INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
    .INIT_DOW(2), .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(72)) u_feb (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .sec_tick(tk[1]), .rdata(rd[1]), .err(er[1]), .per_irq(pi[1]));
  rtc_idx_regs #(.CLK_HZ(CLK_HZ), .INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
    .INIT_DOW(1), .INIT_DOM(28), .INIT_MON(2), .INIT_YEAR(148)) u_nl (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .sec_tick(tk[2]), .rdata(rd[2]), .err(er[2]), .per_irq(pi[2]));
  rtc_idx_regs #(.CLK_HZ(CLK_HZ), .INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
    .INIT_DOW(0), .INIT_DOM(30), .INIT_MON(4), .INIT_YEAR(71)) u_apr (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .sec_tick(tk[3]), .rdata(rd[3]), .err(er[3]), .per_irq(pi[3]));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_ix(input logic [7:0] ix);
    @(negedge clk); idx_wr = 1'b1; wdata = ix;
    @(negedge clk); idx_wr = 1'b0; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic tick(input int which, input int n);
    @(negedge clk); tk[which] = 1'b1;
    repeat (n) @(negedge clk);
    tk[which] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 per_irq", int'(pi[0]), 0);
    chk("R12 err", int'(er[0]), 0);
    rd_ix(8'h00); chk("R12 R1 sec", rd[0], 58);
    rd_ix(8'h02); chk("R12 R1 min", rd[0], 59);
    rd_ix(8'h04); chk("R12 R1 hour", rd[0], 23);
    rd_ix(8'h06); chk("R12 R1 dow", rd[0], 6);
    rd_ix(8'h07); chk("R12 R1 dom", rd[0], 31);
    rd_ix(8'h08); chk("R12 R1 mon", rd[0], 12);
    rd_ix(8'h09); chk("R12 R1 year", rd[0], 255);
    chk("R11 good read no err", int'(er[0]), 0);
  endtask

  task automatic t_ctrl;
    rd_ix(8'h0A); chk("R2 first A read", rd[0], 8'hA6);
    rd_ix(8'h0A); chk("R2 second A read", rd[0], 8'h26);
    rd_ix(8'h0A); chk("R2 third A read", rd[0], 8'hA6);
    rd_ix(8'h0B); chk("R3 ctrl B", rd[0], 8'h46);
    rd_ix(8'h0A); chk("R4 value before hold", rd[0], 8'h26);
    rd_ix(8'h0C); chk("R3 ctrl C", rd[0], 8'h00);
    rd_ix(8'h0B);
    repeat (4) @(negedge clk);
    chk("R4 rdata held", rd[0], 8'h46);
  endtask

  task automatic t_err;
    rd_ix(8'h0D); chk("R11 ctrl D err", int'(er[0]), 1);
    chk("R11 ctrl D data", rd[0], 0);
    @(negedge clk); chk("R11 err one cycle", int'(er[0]), 0);
    rd_ix(8'h20); chk("R11 unmapped err", int'(er[0]), 1);
    chk("R11 unmapped data", rd[0], 0);
    @(negedge clk); data_wr = 1'b1; wdata = 8'h11;
    @(negedge clk); data_wr = 1'b0;
    chk("R11 data write err", int'(er[0]), 1);
    rd_ix(8'h00); chk("R11 write ignored sec", rd[0], 58);
    chk("R11 err cleared", int'(er[0]), 0);
  endtask

  task automatic t_roll;
    repeat (3) @(negedge clk);
    rd_ix(8'h00); chk("R5 no tick no change", rd[0], 58);
    tick(0, 1);
    rd_ix(8'h00); chk("R5 sec inc", rd[0], 59);
    rd_ix(8'h02); chk("R5 min held", rd[0], 59);
    tick(0, 1);
    rd_ix(8'h00); chk("R5 sec wrap", rd[0], 0);
    rd_ix(8'h02); chk("R5 min wrap", rd[0], 0);
    rd_ix(8'h04); chk("R5 hour wrap", rd[0], 0);
    rd_ix(8'h06); chk("R6 dow wrap", rd[0], 0);
    rd_ix(8'h07); chk("R9 dom to 1", rd[0], 1);
    rd_ix(8'h08); chk("R9 month to 1", rd[0], 1);
    rd_ix(8'h09); chk("R9 year wrap", rd[0], 0);
  endtask

  task automatic t_apr;
    tick(3, 1);
    rd_ix(8'h07); chk("R7 30-day dom", rd[3], 1);
    rd_ix(8'h08); chk("R7 30-day month", rd[3], 5);
    rd_ix(8'h09); chk("R7 year held", rd[3], 71);
  endtask

  task automatic t_nl;
    tick(2, 1);
    rd_ix(8'h07); chk("R8 y148 dom", rd[2], 1);
    rd_ix(8'h08); chk("R8 y148 month", rd[2], 3);
  endtask

  task automatic t_leap;
    tick(1, 1);
    rd_ix(8'h07); chk("R8 leap day 29", rd[1], 29);
    rd_ix(8'h08); chk("R8 leap month", rd[1], 2);
    rd_ix(8'h06); chk("R6 dow inc", rd[1], 3);
    tick(1, 86400);
    rd_ix(8'h07); chk("R8 after 29th dom", rd[1], 1);
    rd_ix(8'h08); chk("R8 after 29th month", rd[1], 3);
    rd_ix(8'h04); chk("R5 full day hour", rd[1], 0);
    rd_ix(8'h06); chk("R6 dow second day", rd[1], 4);
  endtask

  task automatic t_per;
    int n;
    n = 0;
    while (pi[0] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk("R10 pulse seen", int'(pi[0]), 1);
    @(negedge clk); chk("R10 pulse width", int'(pi[0]), 0);
    for (int k = 0; k < 2; k++) begin
      n = 1;
      while (pi[0] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
      chk("R10 period", n, DIV);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl;
    t_err;
    t_roll;
    t_apr;
    t_nl;
    t_per;
    t_leap;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule